// File: doc/BRIEF.md
# Two-Wire EEPROM Write Controller (Slave Side)

This block is the write side of a serial EEPROM that sits on a two-wire bus. It samples the clock and data lines, finds START and STOP conditions, accepts a chip-select byte with the write direction, loads a word address and gathers data bytes into a one-page buffer. It acknowledges each accepted byte by pulling the data line low during the ninth clock. The array does not change while bytes arrive. Only the STOP that ends the transfer commits the write.

After that STOP, a self-timed programming cycle runs in two ordered phases. The first phase erases every buffered location to 8'hFF. The second phase writes the buffered bytes into a register-based array. While the cycle runs, the device refuses its own chip-select byte, so a master can poll with repeated STARTs until the device acknowledges again. A write-protect pin and a page/byte mode pin decide how much of the buffer reaches the array. A combinational read port exposes the array contents to the surrounding chip.

Top module: `eeprom_wr_slave`

## Requirements
- R1: After reset, `sda_oe_o` and `busy_o` are low and every array location reads 8'hFF.
- R2: Only a first byte after START that equals `{DEV_ADDR, 1'b0}` (7-bit device address, bit 0 = 0 meaning write) is acknowledged. The acknowledge is `sda_oe_o` high while SCL is high in the ninth clock. Any other first byte, including one with bit 0 = 1, is not acknowledged, and every later byte is ignored without an acknowledge until the next START.
- R3: The byte after an accepted command byte is acknowledged, and its low `ADDR_W` bits become the word address.
- R4: Each data byte is acknowledged and held in the page buffer. The array is unchanged until STOP.
- R5: A STOP after at least one complete data byte, with `wp_i` low, raises `busy_o` for exactly `PROG_CYCLES` clocks. During the first `PROG_CYCLES/2` of those clocks, the buffered locations read 8'hFF. Once the cycle ends, they hold the buffered bytes.
- R6: With `page_en_i` high, the low 3 address bits advance after each data byte and wrap within the 8-byte page. A ninth or later byte overwrites the buffer entry at its wrapped position.
- R7: With `page_en_i` low, only the first data byte of a transfer is stored. Later data bytes are acknowledged but discarded.
- R8: If `wp_i` is high at the STOP, the data bytes are still acknowledged, but no programming cycle starts: `busy_o` stays low and the array is unchanged.
- R9: A STOP that comes before any complete data byte starts no programming cycle.
- R10: While `busy_o` is high, a matching command byte is not acknowledged. After the cycle ends, it is acknowledged again.
- R11: Locations that are not in the buffered set keep their values through a programming cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the bus lines are oversampled with it |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe_o | output | 1 | High to pull the data line low (acknowledge) |
| wp_i | input | 1 | Write protect; high at STOP blocks programming |
| page_en_i | input | 1 | High: page write; low: single-byte write |
| busy_o | output | 1 | Programming cycle in progress |
| rd_addr_i | input | ADDR_W | Array read address |
| rd_data_o | output | 8 | Array contents at `rd_addr_i` |

## Verification
The bench builds the block with `ADDR_W` = 7, `DEV_ADDR` = 7'h50 and `PROG_CYCLES` = 400 instead of the multi-millisecond default. This keeps a full programming cycle to a few hundred clocks. The cycle is still long enough that a complete START plus command byte fits inside the busy window, so the refused poll and the later accepted poll both occur in one run. The 128-byte array is small enough for the bench to sweep and compare every location on each clock. This makes the erase-phase 8'hFF window, the page wrap and the untouched neighbours all visible at the read port.

// File: rtl/eew_pkg.sv
package eew_pkg;

    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_CMD  = 2'd1,
        RX_ADDR = 2'd2,
        RX_DATA = 2'd3
    } rx_state_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ERASE = 2'd1,
        PH_WRITE = 2'd2
    } prog_phase_e;

endpackage

// File: rtl/eew_pin_sync.sv
module eew_pin_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s_o,
    output logic sda_s_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl_pipe;
        logic [SYNC_STAGES-1:0] sda_pipe;
        logic                   scl_prev;
        logic                   sda_prev;
    } sync_t;

    sync_t q, d;

    logic scl_now, sda_now;

    always_comb begin
        d          = q;
        d.scl_pipe = {q.scl_pipe[SYNC_STAGES-2:0], scl_i};
        d.sda_pipe = {q.sda_pipe[SYNC_STAGES-2:0], sda_i};
        d.scl_prev = q.scl_pipe[SYNC_STAGES-1];
        d.sda_prev = q.sda_pipe[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign scl_now    = q.scl_pipe[SYNC_STAGES-1];
    assign sda_now    = q.sda_pipe[SYNC_STAGES-1];
    assign scl_s_o    = scl_now;
    assign sda_s_o    = sda_now;
    assign scl_rise_o = scl_now & ~q.scl_prev;
    assign scl_fall_o = ~scl_now & q.scl_prev;
    assign start_o    = scl_now & q.scl_prev & q.sda_prev & ~sda_now;
    assign stop_o     = scl_now & q.scl_prev & ~q.sda_prev & sda_now;

endmodule

// File: rtl/eew_rx_fsm.sv
module eew_rx_fsm
    import eew_pkg::*;
#(
    parameter int          ADDR_W     = 7,
    parameter int          PAGE_BYTES = 8,
    parameter logic [6:0]  DEV_ADDR   = 7'h50,
    localparam int         OFF_W      = $clog2(PAGE_BYTES),
    localparam int         PG_W       = ADDR_W - OFF_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      scl_rise_i,
    input  logic                      scl_fall_i,
    input  logic                      sda_s_i,
    input  logic                      start_i,
    input  logic                      stop_i,
    input  logic                      busy_i,
    input  logic                      wp_i,
    input  logic                      page_en_i,
    output logic                      sda_oe_o,
    output logic                      launch_o,
    output logic [PG_W-1:0]           page_o,
    output logic [PAGE_BYTES-1:0]     mask_o,
    output logic [PAGE_BYTES*8-1:0]   buf_o
);

    localparam logic [7:0] CMD_WRITE = {DEV_ADDR, 1'b0};

    typedef struct packed {
        rx_state_e                     st;
        logic [3:0]                    bitcnt;
        logic                          ack_ph;
        logic [7:0]                    shreg;
        logic                          sda_oe;
        logic [ADDR_W-1:0]             addr;
        logic [PAGE_BYTES-1:0]         mask;
        logic [PAGE_BYTES-1:0][7:0]    buffer;
        logic                          got;
        logic                          launch;
    } rx_t;

    rx_t q, d;

    logic [OFF_W-1:0] slot;
    assign slot = q.addr[OFF_W-1:0];

    always_comb begin
        d        = q;
        d.launch = 1'b0;
        if (start_i) begin
            d.st     = RX_CMD;
            d.bitcnt = '0;
            d.ack_ph = 1'b0;
            d.sda_oe = 1'b0;
        end else if (stop_i) begin
            if (q.st == RX_DATA && q.got && !wp_i) d.launch = 1'b1;
            d.st     = RX_IDLE;
            d.ack_ph = 1'b0;
            d.sda_oe = 1'b0;
        end else if (q.st != RX_IDLE) begin
            if (scl_rise_i && q.bitcnt < 4'd8) begin
                d.shreg  = {q.shreg[6:0], sda_s_i};
                d.bitcnt = q.bitcnt + 4'd1;
            end else if (scl_fall_i && q.ack_ph) begin
                d.sda_oe = 1'b0;
                d.ack_ph = 1'b0;
                d.bitcnt = '0;
            end else if (scl_fall_i && q.bitcnt == 4'd8) begin
                d.ack_ph = 1'b1;
                unique case (q.st)
                    RX_CMD: begin
                        if (q.shreg == CMD_WRITE && !busy_i) begin
                            d.sda_oe = 1'b1;
                            d.st     = RX_ADDR;
                        end else begin
                            d.st     = RX_IDLE;
                            d.ack_ph = 1'b0;
                        end
                    end
                    RX_ADDR: begin
                        d.addr   = q.shreg[ADDR_W-1:0];
                        d.mask   = '0;
                        d.got    = 1'b0;
                        d.sda_oe = 1'b1;
                        d.st     = RX_DATA;
                    end
                    RX_DATA: begin
                        d.sda_oe = 1'b1;
                        if (page_en_i || !q.got) begin
                            d.buffer[slot] = q.shreg;
                            d.mask[slot]   = 1'b1;
                            d.got          = 1'b1;
                            if (page_en_i) d.addr[OFF_W-1:0] = slot + 1'b1;
                        end
                    end
                    default: d.st = RX_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sda_oe_o = q.sda_oe;
    assign launch_o = q.launch;
    assign page_o   = q.addr[ADDR_W-1:OFF_W];
    assign mask_o   = q.mask;
    assign buf_o    = q.buffer;

endmodule

// File: rtl/eew_prog_seq.sv
module eew_prog_seq
    import eew_pkg::*;
#(
    parameter int PROG_CYCLES = 400000,
    localparam int ERASE_LEN  = PROG_CYCLES / 2,
    localparam int CNT_W      = $clog2(PROG_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch_i,
    output logic busy_o,
    output logic erase_en_o,
    output logic wr_en_o
);

    typedef struct packed {
        prog_phase_e       ph;
        logic [CNT_W-1:0]  cnt;
        logic              erase;
        logic              wr;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d       = q;
        d.erase = 1'b0;
        d.wr    = 1'b0;
        unique case (q.ph)
            PH_IDLE: begin
                if (launch_i) begin
                    d.ph    = PH_ERASE;
                    d.cnt   = '0;
                    d.erase = 1'b1;
                end
            end
            PH_ERASE: begin
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == CNT_W'(ERASE_LEN - 1)) begin
                    d.ph = PH_WRITE;
                    d.wr = 1'b1;
                end
            end
            PH_WRITE: begin
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == CNT_W'(PROG_CYCLES - 1)) d.ph = PH_IDLE;
            end
            default: d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o     = (q.ph != PH_IDLE);
    assign erase_en_o = q.erase;
    assign wr_en_o    = q.wr;

endmodule

// File: rtl/eew_array.sv
module eew_array #(
    parameter int  ADDR_W     = 7,
    parameter int  PAGE_BYTES = 8,
    localparam int OFF_W      = $clog2(PAGE_BYTES),
    localparam int PG_W       = ADDR_W - OFF_W,
    localparam int DEPTH      = 1 << ADDR_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     erase_en_i,
    input  logic                     wr_en_i,
    input  logic [PG_W-1:0]          page_i,
    input  logic [PAGE_BYTES-1:0]    mask_i,
    input  logic [PAGE_BYTES*8-1:0]  buf_i,
    input  logic [ADDR_W-1:0]        rd_addr_i,
    output logic [7:0]               rd_data_o
);

    logic [DEPTH-1:0][7:0] words;

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        localparam logic [PG_W-1:0] MY_PAGE = PG_W'(i / PAGE_BYTES);
        localparam int              MY_OFF  = i % PAGE_BYTES;

        logic       hit;
        logic [7:0] word_q;

        assign hit = (page_i == MY_PAGE) && mask_i[MY_OFF];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                word_q <= 8'hFF;
            else if (hit && erase_en_i) word_q <= 8'hFF;
            else if (hit && wr_en_i)    word_q <= buf_i[MY_OFF*8 +: 8];
        end

        assign words[i] = word_q;
    end

    assign rd_data_o = words[rd_addr_i];

endmodule

// File: rtl/eeprom_wr_slave.sv
module eeprom_wr_slave #(
    parameter int         ADDR_W      = 7,
    parameter int         PAGE_BYTES  = 8,
    parameter logic [6:0] DEV_ADDR    = 7'h50,
    parameter int         PROG_CYCLES = 400000,
    parameter int         SYNC_STAGES = 2,
    localparam int        OFF_W       = $clog2(PAGE_BYTES),
    localparam int        PG_W        = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic              wp_i,
    input  logic              page_en_i,
    output logic              busy_o,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [7:0]        rd_data_o
);

    logic                    scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;
    logic                    launch, erase_en, wr_en;
    logic [PG_W-1:0]         page;
    logic [PAGE_BYTES-1:0]   mask;
    logic [PAGE_BYTES*8-1:0] pbuf;

    eew_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_s_o    (scl_s),
        .sda_s_o    (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_c),
        .stop_o     (stop_c)
    );

    eew_rx_fsm #(
        .ADDR_W     (ADDR_W),
        .PAGE_BYTES (PAGE_BYTES),
        .DEV_ADDR   (DEV_ADDR)
    ) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .sda_s_i    (sda_s),
        .start_i    (start_c),
        .stop_i     (stop_c),
        .busy_i     (busy_o),
        .wp_i       (wp_i),
        .page_en_i  (page_en_i),
        .sda_oe_o   (sda_oe_o),
        .launch_o   (launch),
        .page_o     (page),
        .mask_o     (mask),
        .buf_o      (pbuf)
    );

    eew_prog_seq #(.PROG_CYCLES(PROG_CYCLES)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch_i   (launch),
        .busy_o     (busy_o),
        .erase_en_o (erase_en),
        .wr_en_o    (wr_en)
    );

    eew_array #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_mem (
        .clk        (clk),
        .rst_n      (rst_n),
        .erase_en_i (erase_en),
        .wr_en_i    (wr_en),
        .page_i     (page),
        .mask_i     (mask),
        .buf_i      (pbuf),
        .rd_addr_i  (rd_addr_i),
        .rd_data_o  (rd_data_o)
    );

endmodule

// File: rtl/eew_checker.sv
module eew_checker #(
    parameter int PROG_CYCLES = 400000
) (
    input logic clk,
    input logic rst_n,
    input logic wp_i,
    input logic busy_o,
    input logic sda_oe_o,
    input logic scl_s,
    input logic erase_en,
    input logic wr_en
);

    int   busy_len;
    logic erased_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_len    <= 0;
            erased_seen <= 1'b0;
        end else begin
            busy_len <= busy_o ? busy_len + 1 : 0;
            if (erase_en)     erased_seen <= 1'b1;
            else if (!busy_o) erased_seen <= 1'b0;
        end
    end

    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> busy_len == PROG_CYCLES);                 // R5

    AST_ERASE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> erased_seen);                                     // R5

    AST_WP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> !$past(wp_i, 2));                         // R8

    AST_NO_ACK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !$rose(sda_oe_o));                               // R10

    AST_ACK_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_s);                                // R2

endmodule

bind eeprom_wr_slave eew_checker #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wp_i     (wp_i),
    .busy_o   (busy_o),
    .sda_oe_o (sda_oe_o),
    .scl_s    (scl_s),
    .erase_en (erase_en),
    .wr_en    (wr_en)
);

// File: tb/tb_eeprom_wr_slave.sv
`timescale 1ns/1ps
module tb_eeprom_wr_slave;

    localparam int         AW    = 7;
    localparam int         DEPTH = 1 << AW;
    localparam int         PROG  = 400;
    localparam logic [6:0] DEV   = 7'h50;
    localparam int         H     = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scl_m = 1'b1, sda_m = 1'b1;
    logic          sda_oe_o, busy_o;
    logic          wp_i = 1'b0, page_en_i = 1'b1;
    logic [AW-1:0] rd_addr = '0;
    logic [AW-1:0] probe_addr = '0;
    logic [7:0]    rd_data_o;
    wire           sda_bus = sda_m & ~sda_oe_o;

    int checks = 0, failures = 0;
    bit cmp_en = 1'b0;
    logic [7:0] model_mem [DEPTH];

    always #10 clk = ~clk;

    eeprom_wr_slave #(
        .ADDR_W(AW), .PAGE_BYTES(8), .DEV_ADDR(DEV), .PROG_CYCLES(PROG), .SYNC_STAGES(2)
    ) dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe_o),
        .wp_i(wp_i), .page_en_i(page_en_i), .busy_o(busy_o),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data_o)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // continuous sweep of the whole array against the model (R4, R11)
    always @(negedge clk) begin
        if (cmp_en)
            chk(rd_data_o === model_mem[rd_addr], "R11", "array sweep", rd_data_o, model_mem[rd_addr]);
        rd_addr <= cmp_en ? rd_addr + 1'b1 : probe_addr;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start;
        scl_m = 1'b1; sda_m = 1'b1; tick(H);
        sda_m = 1'b0; tick(H);
        scl_m = 1'b0; tick(H);
    endtask

    task automatic i2c_stop;
        sda_m = 1'b0; tick(H);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b1; tick(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(H);
            scl_m = 1'b1; tick(H);
            scl_m = 1'b0; tick(H);
        end
        sda_m = 1'b1; tick(H);
        scl_m = 1'b1; tick(H / 2);
        acked = sda_oe_o;
        tick(H - H / 2);
        scl_m = 1'b0; tick(H);
    endtask

    // expected buffer contents from the requirements (R6, R7)
    task automatic build_expect(input logic [7:0] a, input logic [7:0] dq[$], input bit pg,
                                output logic [7:0] eb[8], output bit ev[8]);
        int idx = int'(a[2:0]);
        for (int k = 0; k < 8; k++) begin eb[k] = 8'h00; ev[k] = 1'b0; end
        foreach (dq[k]) begin
            if (pg || k == 0) begin
                eb[idx] = dq[k]; ev[idx] = 1'b1;
                if (pg) idx = (idx + 1) % 8;
            end
        end
    endtask

    task automatic commit(input logic [7:0] a, input logic [7:0] eb[8], input bit ev[8]);
        for (int k = 0; k < 8; k++)
            if (ev[k]) model_mem[{a[AW-1:3], 3'(k)}] = eb[k];
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] dq[$], input bit pg,
                            input bit wpv, input string req);
        bit ack;
        logic [7:0] eb[8];
        bit ev[8];
        bit expect_prog;
        page_en_i = pg; wp_i = wpv;
        i2c_start;
        send_byte({DEV, 1'b0}, ack);
        chk(ack, "R2", "command ack", ack, 1);
        send_byte(a, ack);
        chk(ack, "R3", "address ack", ack, 1);
        foreach (dq[k]) begin
            send_byte(dq[k], ack);
            chk(ack, "R4", {req, " data ack"}, ack, 1);
        end
        build_expect(a, dq, pg, eb, ev);
        expect_prog = (dq.size() > 0) && !wpv;
        cmp_en = 1'b0;
        i2c_stop;
        if (expect_prog) begin
            chk(busy_o === 1'b1, "R5", {req, " busy after stop"}, busy_o, 1);
            tick(PROG + 10);
            chk(busy_o === 1'b0, "R5", {req, " busy cleared"}, busy_o, 0);
            commit(a, eb, ev);
        end else begin
            chk(busy_o === 1'b0, req, "no programming", busy_o, 0);
            tick(20);
            chk(busy_o === 1'b0, req, "still idle", busy_o, 0);
        end
        cmp_en = 1'b1;
        tick(DEPTH + 4);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stim
        bit ack;
        logic [7:0] q[$];
        for (int k = 0; k < DEPTH; k++) model_mem[k] = 8'hFF;
        tick(5);
        rst_n = 1'b1;
        tick(2);
        // R1: reset state
        chk(sda_oe_o === 1'b0, "R1", "sda_oe after reset", sda_oe_o, 0);
        chk(busy_o === 1'b0, "R1", "busy after reset", busy_o, 0);
        cmp_en = 1'b1;
        tick(DEPTH + 4);

        // single byte in page mode (R4, R5)
        q = '{8'hA5};
        do_write(8'h05, q, 1'b1, 1'b0, "R5");

        // three-byte page write, then rewrite middle byte with erase check (R5)
        q = '{8'h11, 8'h22, 8'h33};
        do_write(8'h10, q, 1'b1, 1'b0, "R6");
        page_en_i = 1'b1; wp_i = 1'b0;
        i2c_start;
        send_byte({DEV, 1'b0}, ack);
        send_byte(8'h11, ack);
        send_byte(8'h5C, ack);
        chk(ack, "R4", "rewrite data ack", ack, 1);
        cmp_en = 1'b0; probe_addr = 7'h11;
        tick(2);
        chk(rd_data_o === 8'h22, "R4", "old value before stop", rd_data_o, 8'h22);
        i2c_stop;
        tick(PROG / 4);
        chk(rd_data_o === 8'hFF, "R5", "erase phase reads ones", rd_data_o, 8'hFF);
        tick(PROG / 2);
        chk(rd_data_o === 8'h5C, "R5", "write phase value", rd_data_o, 8'h5C);
        tick(PROG / 4 + 10);
        model_mem[7'h11] = 8'h5C;
        cmp_en = 1'b1;
        tick(DEPTH + 4);

        // page wrap (R6)
        q = '{8'hC1, 8'hC2, 8'hC3, 8'hC4};
        do_write(8'h1E, q, 1'b1, 1'b0, "R6");
        q = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08, 8'h09, 8'h0A};
        do_write(8'h20, q, 1'b1, 1'b0, "R6");

        // byte mode (R7)
        q = '{8'h77, 8'h88, 8'h99};
        do_write(8'h30, q, 1'b0, 1'b0, "R7");

        // write protect (R8)
        q = '{8'hEE, 8'hDD};
        do_write(8'h05, q, 1'b1, 1'b1, "R8");

        // stop after address only (R9)
        q = {};
        do_write(8'h40, q, 1'b1, 1'b0, "R9");

        // foreign address and read-direction byte are refused (R2)
        wp_i = 1'b0;
        i2c_start;
        send_byte(8'hB0, ack);
        chk(!ack, "R2", "foreign address nack", ack, 0);
        send_byte(8'h50, ack);
        chk(!ack, "R2", "following byte ignored", ack, 0);
        send_byte(8'h12, ack);
        chk(!ack, "R2", "data after refused ignored", ack, 0);
        i2c_stop;
        chk(busy_o === 1'b0, "R2", "no programming after refusal", busy_o, 0);
        i2c_start;
        send_byte({DEV, 1'b1}, ack);
        chk(!ack, "R2", "read direction nack", ack, 0);
        i2c_stop;
        tick(DEPTH + 4);

        // acknowledge polling (R10)
        page_en_i = 1'b1;
        i2c_start;
        send_byte({DEV, 1'b0}, ack);
        send_byte(8'h50, ack);
        send_byte(8'h3C, ack);
        cmp_en = 1'b0;
        i2c_stop;
        i2c_start;
        send_byte({DEV, 1'b0}, ack);
        chk(!ack, "R10", "command refused while busy", ack, 0);
        chk(busy_o === 1'b1, "R10", "still busy during poll", busy_o, 1);
        i2c_stop;
        tick(PROG);
        chk(busy_o === 1'b0, "R10", "cycle finished", busy_o, 0);
        model_mem[7'h50] = 8'h3C;
        i2c_start;
        send_byte({DEV, 1'b0}, ack);
        chk(ack, "R10", "command accepted after cycle", ack, 1);
        i2c_stop;
        cmp_en = 1'b1;
        tick(DEPTH + 4);
        chk(busy_o === 1'b0, "R9", "poll with no data starts nothing", busy_o, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule